// File: doc/BRIEF.md
# Page-Bounded Chaining DMA Engine

This block is a bus-mastering copy engine that moves 32-bit words between a single device port and memory without help from the processor. Software programs a start address, a byte count and a setup word (device number, direction, chain-continue flag) through a small word-indexed register window, then writes a start bit. The engine asks the system arbiter for the bus, waits for the grant, moves one word in every granted cycle and drops its request once the last word has moved.

Each request is confined to one 4 KB physical page. A request that is misaligned or that would run past the end of its page is refused with an error before any bus activity. Requests may be chained: when a finishing request carries the chain-continue flag, the engine takes whatever the address, count and setup registers hold at that moment as the next request. Software rewrites those registers while the engine is busy. Only the end of the whole chain, or an error, raises the interrupt.

Top module: `dmaPageChain`

## Requirements
- R1: After reset the STATUS word reads zero, busReq is low and irq is low.
- R2: A write of 1 to bit 0 of CTRL (word 0) while idle latches ADDR (word 2), COUNT (word 3) and SETUP (word 4: device number in bits 3:0, direction in bit 8 with 1 meaning memory to device, chain flag in bit 16) and sets busy (STATUS word 1, bit 0). A start write while busy has no effect.
- R3: busReq is raised before any beat, and a beat (devStrobe) happens only in a cycle where busGrant is high. It moves one word at busAddr, beginning at ADDR and rising by 4 on each beat.
- R4: busReq stays high from its rise until the beat that moves the last word, and it falls in the cycle after that beat.
- R5: With direction 0 each beat writes devRdData to memory (busWrEn high, busWrData carries it). With direction 1 each beat presents busRdData on devWrData and does not write memory. devId shows the latched device number.
- R6: A byte count of zero finishes with done set two cycles after the start write, and busReq is never raised.
- R7: An ADDR whose bits 1:0 are nonzero, or a COUNT whose bits 1:0 are nonzero, sets error one cycle after the start write, with no bus activity.
- R8: A request whose address offset within its page plus its byte count exceeds 4096 sets error with no bus activity. A request that ends exactly on the page end is accepted.
- R9: A request finishing with its chain flag set loads the current ADDR, COUNT and SETUP as the next request and continues without raising irq. irq stays low throughout the chain and done is set only after the last request.
- R10: STATUS bit 1 is done and bit 2 is error, and irq is high whenever either is set. Writing 1 to a bit of STATUS clears it, and an accepted start clears both. With full grant, done appears N+2 cycles after the start write for N words.
- R11: An error in a chained request stops the chain with error set and done clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| busReq | output | 1 | Bus request to the arbiter |
| busGrant | input | 1 | Bus grant from the arbiter |
| busAddr | output | 32 | Memory byte address of the current word |
| busWrEn | output | 1 | Memory write strobe for the current beat |
| busWrData | output | 32 | Memory write data |
| busRdData | input | 32 | Memory read data for busAddr |
| devId | output | 4 | Device number of the active request |
| devStrobe | output | 1 | Beat strobe toward the device |
| devRdData | input | 32 | Word supplied by the device |
| devWrData | output | 32 | Word delivered to the device |
| irq | output | 1 | Interrupt: done or error pending |

## Verification
The start write is taken at one edge, and the refused or accepted verdict follows at the next. An error is therefore readable one cycle after the start write, a zero-count done two cycles after it, and an N-word done N+2 cycles after it when the grant is held high. The first beat falls in the second cycle after the start. The directed latency cases step the bench a fixed number of falling edges from the start write and read STATUS there, once before and once after the expected edge. Randomized cases with a grant that comes and goes wait for busy to clear. They then compare memory and the captured device words against patterns computed in the bench.

// File: rtl/dmaPkg.sv
package dmaPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_BUS,
    ST_FINISH
  } dmaStateT;

  // Strobes from control to datapath and register file, one cycle each.
  typedef struct packed {
    logic loadActive;
    logic stepBeat;
    logic clearStatus;
    logic setDone;
    logic setErr;
  } dmaStrobeT;

  localparam logic [2:0] OFS_CTRL   = 3'd0;
  localparam logic [2:0] OFS_STATUS = 3'd1;
  localparam logic [2:0] OFS_ADDR   = 3'd2;
  localparam logic [2:0] OFS_COUNT  = 3'd3;
  localparam logic [2:0] OFS_SETUP  = 3'd4;

  localparam int SETUP_DIR_BIT   = 8;
  localparam int SETUP_CHAIN_BIT = 16;

endpackage

// File: rtl/dmaRegFile.sv
module dmaRegFile
  import dmaPkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DEV_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic              busy,
  input  dmaStrobeT         strobe,
  output logic              startPulse,
  output logic [WORD_W-1:0] cfgAddr,
  output logic [WORD_W-1:0] cfgCount,
  output logic [DEV_W-1:0]  cfgDev,
  output logic              cfgDir,
  output logic              cfgChain,
  output logic              irq
);

  logic doneQ;
  logic errQ;
  logic statusWr;
  logic [WORD_W-1:0] setupWord;
  logic [WORD_W-1:0] statusWord;

  assign startPulse = regWrEn && (regAddr == OFS_CTRL) && regWrData[0];
  assign statusWr   = regWrEn && (regAddr == OFS_STATUS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgAddr  <= '0;
      cfgCount <= '0;
      cfgDev   <= '0;
      cfgDir   <= 1'b0;
      cfgChain <= 1'b0;
    end else if (regWrEn) begin
      case (regAddr)
        OFS_ADDR:  cfgAddr <= regWrData;
        OFS_COUNT: cfgCount <= regWrData;
        OFS_SETUP: begin
          cfgDev   <= regWrData[DEV_W-1:0];
          cfgDir   <= regWrData[SETUP_DIR_BIT];
          cfgChain <= regWrData[SETUP_CHAIN_BIT];
        end
        default: ;
      endcase
    end
  end

  // Sticky status: set strobes win over a same-cycle software clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneQ <= 1'b0;
      errQ  <= 1'b0;
    end else if (strobe.clearStatus) begin
      doneQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      doneQ <= strobe.setDone | (doneQ & ~(statusWr & regWrData[1]));
      errQ  <= strobe.setErr  | (errQ  & ~(statusWr & regWrData[2]));
    end
  end

  assign irq = doneQ | errQ;

  always_comb begin
    setupWord = '0;
    setupWord[DEV_W-1:0]      = cfgDev;
    setupWord[SETUP_DIR_BIT]   = cfgDir;
    setupWord[SETUP_CHAIN_BIT] = cfgChain;
  end

  assign statusWord = {{(WORD_W-3){1'b0}}, errQ, doneQ, busy};

  always_comb begin
    case (regAddr)
      OFS_STATUS: regRdData = statusWord;
      OFS_ADDR:   regRdData = cfgAddr;
      OFS_COUNT:  regRdData = cfgCount;
      OFS_SETUP:  regRdData = setupWord;
      default:    regRdData = '0;
    endcase
  end

endmodule

// File: rtl/dmaControl.sv
module dmaControl
  import dmaPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      busGrant,
  input  logic      actBad,
  input  logic      actEmpty,
  input  logic      lastBeat,
  input  logic      actChain,
  output dmaStrobeT strobe,
  output logic      busReq,
  output logic      busy
);

  dmaStateT state;
  dmaStateT stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strobe.loadActive  = 1'b1;
          strobe.clearStatus = 1'b1;
          stateNext          = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (actBad) begin
          strobe.setErr = 1'b1;
          stateNext     = ST_IDLE;
        end else if (actEmpty) begin
          stateNext = ST_FINISH;
        end else begin
          stateNext = ST_BUS;
        end
      end
      ST_BUS: begin
        if (busGrant) begin
          strobe.stepBeat = 1'b1;
          if (lastBeat) stateNext = ST_FINISH;
        end
      end
      ST_FINISH: begin
        if (actChain) begin
          strobe.loadActive = 1'b1;
          stateNext         = ST_CHECK;
        end else begin
          strobe.setDone = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busReq = (state == ST_BUS);
  assign busy   = (state != ST_IDLE);

endmodule

// File: rtl/dmaDatapath.sv
module dmaDatapath
  import dmaPkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int DEV_W      = 4,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobeT         strobe,
  input  logic [WORD_W-1:0] cfgAddr,
  input  logic [WORD_W-1:0] cfgCount,
  input  logic [DEV_W-1:0]  cfgDev,
  input  logic              cfgDir,
  input  logic              cfgChain,
  input  logic [WORD_W-1:0] busRdData,
  input  logic [WORD_W-1:0] devRdData,
  output logic              actBad,
  output logic              actEmpty,
  output logic              lastBeat,
  output logic              actChain,
  output logic [WORD_W-1:0] busAddr,
  output logic              busWrEn,
  output logic [WORD_W-1:0] busWrData,
  output logic [DEV_W-1:0]  devId,
  output logic              devStrobe,
  output logic [WORD_W-1:0] devWrData
);

  localparam int WORD_BYTES = WORD_W / 8;
  localparam int ALIGN_BITS = $clog2(WORD_BYTES);
  localparam int PAGE_BITS  = $clog2(PAGE_BYTES);
  localparam int WCNT_W     = PAGE_BITS - ALIGN_BITS + 1;

  logic [WORD_W-1:0] actAddr;
  logic [WCNT_W-1:0] actWords;
  logic              actDir;
  logic              misaligned;
  logic              crossesPage;
  logic [WORD_W:0]   endOffset;

  // Validation of the programmed request, judged at the load edge.
  assign misaligned  = (|cfgAddr[ALIGN_BITS-1:0]) || (|cfgCount[ALIGN_BITS-1:0]);
  assign endOffset   = {{(WORD_W-PAGE_BITS+1){1'b0}}, cfgAddr[PAGE_BITS-1:0]} + {1'b0, cfgCount};
  assign crossesPage = endOffset > (WORD_W+1)'(PAGE_BYTES);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actAddr  <= '0;
      actWords <= '0;
      actDir   <= 1'b0;
      actChain <= 1'b0;
      actBad   <= 1'b0;
      actEmpty <= 1'b0;
      devId    <= '0;
    end else if (strobe.loadActive) begin
      actAddr  <= cfgAddr;
      actWords <= cfgCount[PAGE_BITS:ALIGN_BITS];
      actDir   <= cfgDir;
      actChain <= cfgChain;
      actBad   <= misaligned || crossesPage;
      actEmpty <= (cfgCount == '0);
      devId    <= cfgDev;
    end else if (strobe.stepBeat) begin
      actAddr  <= actAddr + WORD_W'(WORD_BYTES);
      actWords <= actWords - WCNT_W'(1);
    end
  end

  assign lastBeat  = (actWords == WCNT_W'(1));
  assign busAddr   = actAddr;
  assign devStrobe = strobe.stepBeat;
  assign busWrEn   = strobe.stepBeat && !actDir;
  assign busWrData = devRdData;
  assign devWrData = busRdData;

endmodule

// File: rtl/dmaPageChain.sv
module dmaPageChain
  import dmaPkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int DEV_W      = 4,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  output logic              busReq,
  input  logic              busGrant,
  output logic [WORD_W-1:0] busAddr,
  output logic              busWrEn,
  output logic [WORD_W-1:0] busWrData,
  input  logic [WORD_W-1:0] busRdData,
  output logic [DEV_W-1:0]  devId,
  output logic              devStrobe,
  input  logic [WORD_W-1:0] devRdData,
  output logic [WORD_W-1:0] devWrData,
  output logic              irq
);

  dmaStrobeT         strobe;
  logic              busy;
  logic              startPulse;
  logic [WORD_W-1:0] cfgAddr;
  logic [WORD_W-1:0] cfgCount;
  logic [DEV_W-1:0]  cfgDev;
  logic              cfgDir;
  logic              cfgChain;
  logic              actBad;
  logic              actEmpty;
  logic              lastBeat;
  logic              actChain;

  dmaRegFile #(.WORD_W(WORD_W), .DEV_W(DEV_W)) uRegs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .busy(busy),
    .strobe(strobe), .startPulse(startPulse), .cfgAddr(cfgAddr),
    .cfgCount(cfgCount), .cfgDev(cfgDev), .cfgDir(cfgDir),
    .cfgChain(cfgChain), .irq(irq)
  );

  dmaControl uCtrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .busGrant(busGrant),
    .actBad(actBad), .actEmpty(actEmpty), .lastBeat(lastBeat),
    .actChain(actChain), .strobe(strobe), .busReq(busReq), .busy(busy)
  );

  dmaDatapath #(.WORD_W(WORD_W), .DEV_W(DEV_W), .PAGE_BYTES(PAGE_BYTES)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgAddr(cfgAddr),
    .cfgCount(cfgCount), .cfgDev(cfgDev), .cfgDir(cfgDir),
    .cfgChain(cfgChain), .busRdData(busRdData), .devRdData(devRdData),
    .actBad(actBad), .actEmpty(actEmpty), .lastBeat(lastBeat),
    .actChain(actChain), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .devId(devId), .devStrobe(devStrobe),
    .devWrData(devWrData)
  );

endmodule

// File: rtl/dmaPageChainChk.sv
module dmaPageChainChk (
  input logic clk,
  input logic rstN,
  input logic busReq,
  input logic busGrant,
  input logic busWrEn,
  input logic devStrobe,
  input logic busy,
  input logic irq
);

  AST_BEAT_GRANTED: assert property (@(posedge clk) disable iff (!rstN)
    devStrobe |-> (busReq && busGrant)); // R3

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !devStrobe) |=> busReq); // R4

  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busReq) |-> $past(devStrobe)); // R4

  AST_WRITE_ON_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn |-> devStrobe); // R5

  AST_IRQ_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !irq); // R9

endmodule

bind dmaPageChain dmaPageChainChk uChk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busGrant(busGrant),
  .busWrEn(busWrEn), .devStrobe(devStrobe), .busy(busy), .irq(irq)
);

// File: tb/sim_dmaPageChain.sv
module sim_dmaPageChain;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [2:0]  regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        busReq;
  logic        busGrant;
  logic [31:0] busAddr;
  logic        busWrEn;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic [3:0]  devId;
  logic        devStrobe;
  logic [31:0] devRdData;
  logic [31:0] devWrData;
  logic        irq;

  always #5 clk = ~clk;

  dmaPageChain u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .busReq(busReq),
    .busGrant(busGrant), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .devId(devId),
    .devStrobe(devStrobe), .devRdData(devRdData), .devWrData(devWrData),
    .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  int devCnt;
  int reqCycles;
  bit fullGrant;
  logic [31:0] mem    [0:2047];
  logic [31:0] capBuf [0:2047];

  function automatic logic [31:0] memInit(int i);
    return (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] devPat(logic [3:0] id, int n);
    return {8'hD0, 4'h0, id, n[15:0]};
  endfunction

  function automatic logic [31:0] setupVal(int dev, int dir, int chain);
    return 32'(dev & 15) | (32'(dir & 1) << 8) | (32'(chain & 1) << 16);
  endfunction

  assign busRdData = mem[busAddr[12:2]];
  assign devRdData = devPat(devId, devCnt);

  // Memory, device and bus activity models.
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 2048; i++) mem[i] <= memInit(i);
      devCnt    <= 0;
      reqCycles <= 0;
    end else begin
      if (busWrEn) mem[busAddr[12:2]] <= busWrData;
      if (devStrobe) begin
        capBuf[devCnt % 2048] <= devWrData;
        devCnt <= devCnt + 1;
      end
      if (busReq) reqCycles <= reqCycles + 1;
    end
  end

  always @(negedge clk) begin
    if (!rstN) busGrant <= 1'b0;
    else       busGrant <= busReq && (fullGrant || ($urandom % 4 != 0));
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readStatus(output logic [31:0] s);
    regAddr = 3'd1;
    #1;
    s = regRdData;
  endtask

  task automatic setReq(input int addr, input int bytes, input int dev,
                        input int dir, input int chain);
    regWrite(3'd2, 32'(addr));
    regWrite(3'd3, 32'(bytes));
    regWrite(3'd4, setupVal(dev, dir, chain));
  endtask

  task automatic waitIdle(input string tag);
    logic [31:0] s;
    int n = 0;
    bit irqBusy = 0;
    do begin
      @(negedge clk);
      readStatus(s);
      if (s[0] && irq) irqBusy = 1;
      n++;
    end while (s[0] && n < 5000);
    check(!irqBusy, "R9", {tag, " irq while busy"}, 32'(irqBusy), 0);
  endtask

  task automatic verify(input string tag, input int addr, input int words,
                        input int dev, input int dir, input int d0);
    bit ok = 1;
    logic [31:0] act = 0, exp = 0;
    for (int i = 0; i < words; i++) begin
      logic [31:0] a, e;
      if (dir == 0) begin
        a = mem[(addr >> 2) + i];
        e = devPat(4'(dev), d0 + i);
      end else begin
        a = capBuf[(d0 + i) % 2048];
        e = mem[(addr >> 2) + i];
      end
      if (ok && a !== e) begin ok = 0; act = a; exp = e; end
    end
    check(ok, dir == 0 ? "R5" : "R3", {tag, " data"}, act, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R1", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] s;
    int d0, r0;
    void'($urandom(32'd1357));
    rstN = 1'b0; regWrEn = 1'b0; regAddr = 3'd0; regWrData = '0; fullGrant = 1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readStatus(s);
    check(s == 0, "R1", "status after reset", s, 0);
    check(!busReq && !irq, "R1", "busReq/irq after reset", {30'b0, busReq, irq}, 0);

    // R10 latency and R5 device to memory, 16 words
    setReq(32'h100, 64, 3, 0, 0);
    d0 = devCnt;
    regWrite(3'd0, 1);
    repeat (17) @(negedge clk);
    readStatus(s);
    check(s[2:0] == 3'b001, "R10", "status one cycle before done", s, 1);
    @(negedge clk);
    readStatus(s);
    check(s[2:0] == 3'b010 && irq, "R10", "done at N+2", s, 2);
    verify("R5 dev->mem", 32'h100, 16, 3, 0, d0);
    regWrite(3'd1, 32'h2);
    readStatus(s);
    check(s == 0 && !irq, "R10", "W1C clears done", s, 0);

    // R5 memory to device
    setReq(32'h1200, 96, 5, 1, 0);
    d0 = devCnt;
    regWrite(3'd0, 1);
    waitIdle("R5 mem->dev");
    verify("R5 mem->dev", 32'h1200, 24, 5, 1, d0);
    check(devCnt - d0 == 24, "R3", "beat count", 32'(devCnt - d0), 24);

    // R6 zero count
    setReq(32'h300, 0, 1, 0, 0);
    r0 = reqCycles;
    regWrite(3'd0, 1);
    @(negedge clk);
    readStatus(s);
    check(s[2:0] == 3'b001, "R6", "zero count still busy", s, 1);
    @(negedge clk);
    readStatus(s);
    check(s[2:0] == 3'b010, "R6", "zero count done", s, 2);
    check(reqCycles == r0, "R6", "no busReq", 32'(reqCycles - r0), 0);

    // R7 misaligned address, then misaligned count
    setReq(32'h102, 16, 1, 0, 0);
    r0 = reqCycles;
    regWrite(3'd0, 1);
    @(negedge clk);
    readStatus(s);
    check(s[2:0] == 3'b100 && irq, "R7", "misaligned addr error", s, 4);
    setReq(32'h100, 6, 1, 0, 0);
    regWrite(3'd0, 1);
    @(negedge clk);
    readStatus(s);
    check(s[2:0] == 3'b100, "R7", "misaligned count error", s, 4);
    check(reqCycles == r0, "R7", "no busReq", 32'(reqCycles - r0), 0);

    // R8 exact page end accepted, crossing refused
    setReq(32'hFF0, 16, 2, 0, 0);
    d0 = devCnt;
    regWrite(3'd0, 1);
    waitIdle("R8 exact");
    readStatus(s);
    check(s[2:0] == 3'b010, "R8", "ends on page end", s, 2);
    verify("R8 exact", 32'hFF0, 4, 2, 0, d0);
    setReq(32'hFF0, 20, 2, 0, 0);
    r0 = reqCycles;
    regWrite(3'd0, 1);
    @(negedge clk);
    readStatus(s);
    check(s[2:0] == 3'b100, "R8", "page cross error", s, 4);
    check(reqCycles == r0, "R8", "no busReq", 32'(reqCycles - r0), 0);

    // R10 accepted start clears error
    setReq(32'h400, 32, 4, 0, 0);
    regWrite(3'd0, 1);
    readStatus(s);
    check(s[2:0] == 3'b001 && !irq, "R10", "start clears error", s, 1);
    waitIdle("R10 start clear");

    // R2 start while busy ignored
    setReq(32'h500, 80, 6, 0, 0);
    r0 = reqCycles;
    regWrite(3'd0, 1);
    setReq(32'h1500, 16, 6, 0, 0);
    regWrite(3'd0, 1);
    waitIdle("R2");
    repeat (4) @(negedge clk);
    readStatus(s);
    check(s[2:0] == 3'b010, "R2", "idle after one request", s, 2);
    check(reqCycles - r0 == 20, "R2", "only first request used bus", 32'(reqCycles - r0), 20);
    check(mem[32'h1500 >> 2] == memInit(32'h1500 >> 2), "R2", "second region untouched",
          mem[32'h1500 >> 2], memInit(32'h1500 >> 2));

    // R9 directed chain
    setReq(32'h40, 80, 1, 0, 1);
    d0 = devCnt;
    regWrite(3'd0, 1);
    setReq(32'h1800, 40, 2, 1, 0);
    waitIdle("R9 chain");
    readStatus(s);
    check(s[2:0] == 3'b010 && irq, "R9", "done at chain end", s, 2);
    verify("R9 first", 32'h40, 20, 1, 0, d0);
    verify("R9 second", 32'h1800, 10, 2, 1, d0 + 20);

    // R11 error in chained request
    setReq(32'h600, 64, 7, 0, 1);
    regWrite(3'd0, 1);
    setReq(32'hFFC, 8, 7, 0, 0);
    waitIdle("R11");
    readStatus(s);
    check(s[2:0] == 3'b100 && irq, "R11", "chain stops on error", s, 4);

    // Randomized requests with an intermittent grant
    fullGrant = 0;
    for (int t = 0; t < 24; t++) begin
      int pg, w1, off, dir, dev, w2, off2, dir2, dev2;
      bit ch;
      pg  = $urandom % 2;
      ch  = (t % 3 == 0);
      w1  = ch ? 12 + $urandom % 36 : 1 + $urandom % 48;
      off = $urandom % (1024 - w1 + 1);
      dir = $urandom % 2;
      dev = $urandom % 16;
      setReq(pg * 4096 + off * 4, w1 * 4, dev, dir, int'(ch));
      d0 = devCnt;
      regWrite(3'd0, 1);
      w2 = 0; off2 = 0; dir2 = 0; dev2 = 0;
      if (ch) begin
        w2   = 1 + $urandom % 32;
        off2 = $urandom % (1024 - w2 + 1);
        dir2 = $urandom % 2;
        dev2 = $urandom % 16;
        setReq((1 - pg) * 4096 + off2 * 4, w2 * 4, dev2, dir2, 0);
      end
      waitIdle("R3 random");
      readStatus(s);
      check(s[2:0] == 3'b010, "R3", "random request done", s, 2);
      verify("R3 random first", pg * 4096 + off * 4, w1, dev, dir, d0);
      if (ch) verify("R9 random second", (1 - pg) * 4096 + off2 * 4, w2, dev2, dir2, d0 + w1);
      regWrite(3'd1, 32'h6);
    end

    summary();
    $finish;
  end

endmodule